// File: doc/BRIEF.md
# Weighted Slowdown and Unfairness Evaluator

This block sits beside a shared-memory request arbiter. For every thread it receives two running stall-time figures: the time the thread has stalled on memory while sharing it with others, and an estimate of the time it would have stalled running alone. It divides the first by the second in fixed point to get a slowdown ratio. The division uses a small reciprocal table indexed by the normalised divisor. It then scales each ratio by a per-thread priority weight supplied by software.

Only threads that currently hold at least one legal request in the arbiter's queue are considered. Among them the block finds the largest and the smallest weighted slowdown. It compares their ratio against a software threshold without dividing, by cross-multiplying. The arbiter receives three results: the index of the most-slowed thread, that thread's weighted slowdown, and a mode flag. The flag selects fairness-first ordering when set and throughput-first ordering when clear.

Every input is sampled state, not a stream, so the interface carries no handshake. The arbiter pulses `upd_stb` once per scheduling decision. The results then hold until the next pulse, and no back-pressure applies.

Top module: `slowdown_fair_eval`

## Requirements
- R1: For each thread, let `a` be its alone time after clamping, `p` the index of the highest set bit of `a`, and `m` the top 4 bits of `a` with its leading one at bit 3 (shifted right by p-3, or left by 3-p when p<3). The slowdown is then `(shared * floor(1024/m)) >> (p+1)`, an unsigned value with 6 fractional bits.
- R2: An alone time of zero is treated as 1, which gives a slowdown of `shared * 64`.
- R3: The weighted slowdown is the slowdown multiplied by the thread's 3-bit weight. A weight of zero counts as 1.
- R4: A thread whose `active` bit is clear has no effect on any result, whatever its stall times and weight.
- R5: `hot_id` is the active thread with the largest weighted slowdown. On a tie the lowest index wins. `hot_sd` is that thread's weighted slowdown.
- R6: With two or more active threads, `fair_mode` is 1 exactly when `max * 64 >= thresh * min`. Here `max` and `min` are the largest and smallest active weighted slowdowns, and `thresh` has 6 fractional bits.
- R7: With fewer than two active threads, `fair_mode` is 0. With no active thread, `hot_id` and `hot_sd` are 0.
- R8: Results are registered. They load on a rising edge where `upd_stb` is 1 and hold otherwise. Reset clears all three results to 0.
- R9: A threshold of 64 (1.0) or below sets `fair_mode` whenever two or more threads are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shared_t | input | NTHR*TW | Shared-run stall time per thread, thread t at bits [t*TW +: TW] |
| alone_t | input | NTHR*TW | Estimated alone-run stall time per thread, same packing |
| weight | input | NTHR*WW | Priority weight per thread, thread t at bits [t*WW +: WW] |
| active | input | NTHR | Bit t set when thread t has an outstanding legal request |
| thresh | input | THW | Unfairness threshold, 6 fractional bits |
| upd_stb | input | 1 | Refresh the results on this edge |
| fair_mode | output | 1 | 1 = fairness-first ordering, 0 = throughput-first |
| hot_id | output | IDW | Index of the most-slowed active thread |
| hot_sd | output | TW+FB+WW | Weighted slowdown of that thread |

## Verification
The path from the inputs to the output registers is purely combinational. Each result therefore changes on the first rising edge at which `upd_stb` is high, and on no other edge. The bench drives the inputs and the strobe on a falling edge and drops the strobe on the next falling edge. It compares all three outputs there, half a cycle after the capturing edge. For the hold checks, the bench changes the inputs with the strobe low and waits two further edges before comparing the outputs with their earlier values.

// File: rtl/sd_eval_pkg.sv
package sd_eval_pkg;
  typedef enum logic {EV_THRU = 1'b0, EV_FAIR = 1'b1} ev_mode_e;

  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sd_recip_unit.sv
module sd_recip_unit #(
  parameter int TW = 12,
  parameter int MB = 4,
  parameter int FB = 6,
  localparam int SDW = TW + FB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [TW-1:0]  shared_i,
  input  logic [TW-1:0]  alone_i,
  output logic [SDW-1:0] sd_o
);
  localparam int LW = $clog2(TW);
  localparam int RW = FB + 2;
  localparam int PW = TW + RW;
  localparam int NE = 1 << MB;

  logic [TW-1:0] a_eff;
  logic [LW-1:0] lead;
  logic [MB-1:0] mant;
  logic [RW-1:0] rtab [NE];
  logic [PW-1:0] prod;

  // reciprocal table: 2^(MB+FB) / mantissa, computed at elaboration
  for (genvar k = 0; k < NE; k++) begin : g_rtab
    assign rtab[k] = RW'((1 << (MB + FB)) / ((k == 0) ? 1 : k));
  end

  assign a_eff = (alone_i == '0) ? TW'(1) : alone_i;

  always_comb begin
    lead = '0;
    for (int i = 0; i < TW; i++) begin
      if (a_eff[i]) lead = LW'(i);
    end
  end

  always_comb begin
    if (int'(lead) >= MB - 1) mant = MB'(a_eff >> (int'(lead) - (MB - 1)));
    else                      mant = MB'(a_eff << ((MB - 1) - int'(lead)));
  end

  assign prod = PW'(shared_i) * PW'(rtab[mant]);
  assign sd_o = SDW'(prod >> (int'(lead) + 1));

  // R1
  sd_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sd_o <= (SDW'(shared_i) << FB));
endmodule

// File: rtl/sd_extrema.sv
module sd_extrema #(
  parameter int NTHR = 4,
  parameter int VW   = 21,
  localparam int IDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NTHR*VW-1:0] val_i,
  input  logic [NTHR-1:0]    act_i,
  output logic               any_o,
  output logic               multi_o,
  output logic [IDW-1:0]     max_id_o,
  output logic [VW-1:0]      max_v_o,
  output logic [VW-1:0]      min_v_o
);
  always_comb begin
    any_o    = 1'b0;
    multi_o  = 1'b0;
    max_id_o = '0;
    max_v_o  = '0;
    min_v_o  = '1;
    for (int t = 0; t < NTHR; t++) begin
      if (act_i[t]) begin
        if (any_o) multi_o = 1'b1;
        if (!any_o || val_i[t*VW +: VW] > max_v_o) begin
          max_v_o  = val_i[t*VW +: VW];
          max_id_o = IDW'(t);
        end
        if (val_i[t*VW +: VW] < min_v_o) min_v_o = val_i[t*VW +: VW];
        any_o = 1'b1;
      end
    end
    if (!any_o) min_v_o = '0;
  end

  // R5
  hot_is_active_chk: assert property (@(posedge clk) disable iff (rst)
    any_o |-> act_i[max_id_o]);

  // R6
  max_ge_min_chk: assert property (@(posedge clk) disable iff (rst)
    any_o |-> (max_v_o >= min_v_o));

  // R4
  none_active_chk: assert property (@(posedge clk) disable iff (rst)
    (act_i == '0) |-> (!any_o && !multi_o && max_v_o == '0));
endmodule

// File: rtl/slowdown_fair_eval.sv
module slowdown_fair_eval
  import sd_eval_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int TW   = 12,
  parameter int WW   = 3,
  parameter int THW  = 12,
  parameter int MB   = 4,
  parameter int FB   = 6,
  localparam int IDW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int WSW = TW + FB + WW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NTHR*TW-1:0]   shared_t,
  input  logic [NTHR*TW-1:0]   alone_t,
  input  logic [NTHR*WW-1:0]   weight,
  input  logic [NTHR-1:0]      active,
  input  logic [THW-1:0]       thresh,
  input  logic                 upd_stb,
  output logic                 fair_mode,
  output logic [IDW-1:0]       hot_id,
  output logic [WSW-1:0]       hot_sd
);
  localparam int SDW  = TW + FB;
  localparam int CMPW = WSW + int'(wider(THW, FB)) + 1;

  logic [NTHR*WSW-1:0] wsd_flat;
  logic                any, multi;
  logic [IDW-1:0]      max_id;
  logic [WSW-1:0]      max_v, min_v;
  logic [CMPW-1:0]     lhs, rhs;
  ev_mode_e            nxt_mode;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [SDW-1:0] sd;
    logic [WW-1:0]  w_eff;

    sd_recip_unit #(.TW(TW), .MB(MB), .FB(FB)) u_rcp (
      .clk      (clk),
      .rst      (rst),
      .shared_i (shared_t[t*TW +: TW]),
      .alone_i  (alone_t[t*TW +: TW]),
      .sd_o     (sd)
    );

    assign w_eff = (weight[t*WW +: WW] == '0) ? WW'(1) : weight[t*WW +: WW];
    assign wsd_flat[t*WSW +: WSW] = WSW'(sd) * WSW'(w_eff);
  end

  sd_extrema #(.NTHR(NTHR), .VW(WSW)) u_ext (
    .clk      (clk),
    .rst      (rst),
    .val_i    (wsd_flat),
    .act_i    (active),
    .any_o    (any),
    .multi_o  (multi),
    .max_id_o (max_id),
    .max_v_o  (max_v),
    .min_v_o  (min_v)
  );

  assign lhs      = CMPW'(max_v) << FB;
  assign rhs      = CMPW'(thresh) * CMPW'(min_v);
  assign nxt_mode = (multi && lhs >= rhs) ? EV_FAIR : EV_THRU;

  always_ff @(posedge clk) begin
    if (rst) begin
      fair_mode <= 1'b0;
      hot_id    <= '0;
      hot_sd    <= '0;
    end else if (upd_stb) begin
      fair_mode <= (nxt_mode == EV_FAIR);
      hot_id    <= max_id;
      hot_sd    <= max_v;
    end
  end

  // R8
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_stb |=> ($stable(fair_mode) && $stable(hot_id) && $stable(hot_sd)));

  // R7
  few_active_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && $countones(active) < 2) |=> !fair_mode);

  // R9
  low_thresh_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && $countones(active) >= 2 && int'(thresh) <= (1 << FB)) |=> fair_mode);
endmodule

// File: tb/slowdown_fair_eval_bench.sv
module slowdown_fair_eval_bench;
  localparam int NTHR = 4, TW = 12, WW = 3, THW = 12, WSW = TW + 6 + WW;

  logic clk = 1'b0, rst = 1'b1, upd_stb = 1'b0;
  logic [NTHR*TW-1:0] shared_t = '0, alone_t = '0;
  logic [NTHR*WW-1:0] weight = '0;
  logic [NTHR-1:0]    active = '0;
  logic [THW-1:0]     thresh = '0;
  logic               fair_mode;
  logic [1:0]         hot_id;
  logic [WSW-1:0]     hot_sd;

  int n_run = 0, n_fail = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  slowdown_fair_eval u_slowdown_fair_eval (
    .clk(clk), .rst(rst), .shared_t(shared_t), .alone_t(alone_t), .weight(weight),
    .active(active), .thresh(thresh), .upd_stb(upd_stb),
    .fair_mode(fair_mode), .hot_id(hot_id), .hot_sd(hot_sd));

  function automatic longint sd_model(input longint sh, input longint al);
    longint a, m;
    int p;
    a = (al == 0) ? 1 : al;
    p = 0;
    for (int i = 0; i < TW; i++) if (a[i]) p = i;
    m = (p >= 3) ? (a >> (p - 3)) : (a << (3 - p));
    return (sh * (1024 / m)) >> (p + 1);
  endfunction

  function automatic int unsigned nxt_rand(input int unsigned s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply();
    @(negedge clk) upd_stb = 1'b1;
    @(negedge clk) upd_stb = 1'b0;
  endtask

  task automatic set_thr(input int t, input longint sh, input longint al, input int w);
    shared_t[t*TW +: TW] = TW'(sh);
    alone_t[t*TW +: TW]  = TW'(al);
    weight[t*WW +: WW]   = WW'(w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check("R8 reset fair", fair_mode, 0);
    check("R8 reset id", hot_id, 0);
    check("R8 reset sd", hot_sd, 0);

    // R1 single active thread, sweep divisor
    for (int al = 0; al < 4096; al += 5) begin
      for (int s = 0; s < 2; s++) begin
        automatic int t = (al / 5) % NTHR;
        automatic longint sh = (s == 0) ? 4095 : 1234;
        shared_t = '1; alone_t = '0; weight = '1;
        set_thr(t, sh, al, 1);
        active = NTHR'(1) << t;
        thresh = THW'(64);
        apply();
        check("R1 slowdown", hot_sd, sd_model(sh, al));
        check("R5 id", hot_id, t);
        check("R7 single fair", fair_mode, 0);
      end
    end

    // R2 zero alone time
    shared_t = '0; alone_t = '0; weight = '0;
    set_thr(2, 777, 0, 1); active = 4'b0100;
    apply();
    check("R2 zero alone", hot_sd, 777 * 64);

    // R3 weights
    for (int w = 0; w < 8; w++) begin
      set_thr(1, 100, 50, w); active = 4'b0010;
      apply();
      check("R3 weight", hot_sd, sd_model(100, 50) * ((w == 0) ? 1 : w));
    end

    // R8 hold without strobe
    begin
      automatic longint o_sd = hot_sd;
      automatic longint o_id = hot_id;
      @(negedge clk);
      set_thr(0, 4000, 1, 7); active = 4'b1111; thresh = '0;
      @(negedge clk); @(negedge clk);
      check("R8 hold sd", hot_sd, o_sd);
      check("R8 hold id", hot_id, o_id);
      check("R8 hold fair", fair_mode, 0);
    end

    // R4 R5 R6 R7 R9 mixed patterns
    for (int mask = 0; mask < 16; mask++) begin
      for (int k = 0; k < 24; k++) begin
        automatic longint wsd[NTHR];
        automatic longint mx = 0, mn = 0;
        automatic int cnt = 0, id = 0, thv;
        automatic int thr_set[6] = '{64, 80, 128, 200, 4095, 0};
        thv = thr_set[k % 6];
        for (int t = 0; t < NTHR; t++) begin
          if (mask[t]) begin
            automatic longint sh, al;
            automatic int w;
            seed = nxt_rand(seed); sh = (seed >> 8) % 4096;
            seed = nxt_rand(seed); al = (seed >> 8) % ((k % 3 == 0) ? 16 : 4096);
            seed = nxt_rand(seed); w = (seed >> 8) % 8;
            if (k == 5) begin sh = 900; al = 300; w = 2; end
            set_thr(t, sh, al, w);
            wsd[t] = sd_model(sh, al) * ((w == 0) ? 1 : w);
            if (cnt == 0 || wsd[t] > mx) begin mx = wsd[t]; id = t; end
            if (cnt == 0 || wsd[t] < mn) mn = wsd[t];
            cnt++;
          end else begin
            set_thr(t, 4095, 1, 7);
          end
        end
        active = NTHR'(mask); thresh = THW'(thv);
        apply();
        check("R4 R5 top sd", hot_sd, (cnt == 0) ? 0 : mx);
        check("R5 hot id", hot_id, (cnt == 0) ? 0 : id);
        if (cnt < 2) check("R7 fair off", fair_mode, 0);
        else check("R6 fair mode", fair_mode, (mx * 64 >= thv * mn) ? 1 : 0);
        if (cnt >= 2 && thv <= 64) check("R9 low threshold", fair_mode, 1);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule